// File: doc/BRIEF.md
# Shared Parallel-Port Steering with Clock Bus Sequencing

This block lets one 8-bit parallel data port be shared among three peripherals that sit on it: a sound generator, a real-time clock with a multiplexed address/data bus, and a write-only interval timer. A write-only extension register, reached through a partial decode of the I/O address, picks which peripheral owns the port. The same register also drives a video blanking force and three display mode selects. The sound generator, the clock and the timer are not part of the block. It produces only their bus strobes and moves data between them and the port.

When the clock owns the port, software runs its bus cycles through three bits of a second parallel port. Each cycle samples those bits and turns them into registered address-strobe, data-strobe and read-direction outputs. During a clock read cycle only, the clock's data is returned on the port's input lines. When the timer enable bit is set, every I/O write also produces a timer write strobe. The timer register is chosen by the two low address bits, and the data comes from the parallel port's output lines.

Top module: `busSteer`

## Requirements
- R1: While reset is held, all six stored extension bits are 0. Then videoBlank, extColor, hiResX and modeAux are 0, the clock strobes rtcAs, rtcDs and rtcRead are 0, and the sound generator owns the port.
- R2: The extension register loads only in a cycle with ioWr=1, ioAddr[10]=0, ioAddr[8]=0 and ioAddr[7]=1. The new value shows on the outputs from the next cycle. The register keeps ioData[5:0] as follows: bit 5 routes to the clock, bit 4 enables the timer, bit 3 drives videoBlank, bit 2 drives extColor, bit 1 drives hiResX and bit 0 drives modeAux. ioData[7:6] and writes to any other address change nothing.
- R3: With bit 5 = 0, soundCtlOut equals soundCtlIn, portAIn equals soundDataIn, and the clock strobes are 0 from the cycle after the routing was sampled.
- R4: With bit 5 = 1, soundCtlOut is held at 0 whatever soundCtlIn is.
- R5: With the clock routed, ctlBits = 2 (bit 2 data strobe, bit 1 address strobe, bit 0 direction) gives rtcAs=1 with rtcDs=0 one clock edge after it is sampled. rtcAs and rtcDs are never high together.
- R6: With the clock routed, ctlBits = 4 gives rtcDs=1 and rtcRead=0 one edge later, and rtcBusDrive=1 so the port's output data reaches rtcBusOut.
- R7: With the clock routed, ctlBits = 5 gives rtcDs=1 and rtcRead=1 one edge later. portAIn then equals rtcDataIn and rtcBusDrive is 0.
- R8: With the clock routed, any other ctlBits value leaves rtcAs, rtcDs and rtcRead at 0 after the next edge, and portAIn reads 8'hFF.
- R9: With bit 4 = 1, every cycle with ioWr=1 raises tmrWr in that same cycle, with tmrAddr = ioAddr[1:0] and tmrData = portAOut. With bit 4 = 0, tmrWr stays 0. The timer has no read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write cycle, one per clock |
| portAOut | input | 8 | Data the parallel port drives outward |
| portAIn | output | 8 | Data returned to the parallel port input |
| ctlBits | input | 3 | Clock cycle control bits from the second port |
| soundCtlIn | input | 2 | Sound generator bus-control bits requested by software |
| soundCtlOut | output | 2 | Gated sound generator bus-control bits |
| soundDataOut | output | 8 | Data toward the sound generator |
| soundDataIn | input | 8 | Data from the sound generator |
| rtcAs | output | 1 | Clock address strobe |
| rtcDs | output | 1 | Clock data strobe |
| rtcRead | output | 1 | Clock direction, 1 = read |
| rtcBusOut | output | 8 | Data toward the clock bus |
| rtcBusDrive | output | 1 | Enable to drive rtcBusOut onto the clock bus |
| rtcDataIn | input | 8 | Data from the clock bus |
| tmrWr | output | 1 | Timer write strobe |
| tmrAddr | output | 2 | Timer register select |
| tmrData | output | 8 | Timer write data |
| videoBlank | output | 1 | Force video to black |
| extColor | output | 1 | Extended colour / mapper mode |
| hiResX | output | 1 | High horizontal resolution |
| modeAux | output | 1 | Auxiliary video address decode select |

## Verification
A wrong stored extension bit shows up on the cycle after the write that set it. It appears directly on one of the four mode outputs, as sound control lines that stay gated, or as a timer strobe on an unrelated write. A wrong registered clock phase appears one edge after the control bits are sampled, as a misplaced or doubled strobe. Because the read mux follows that registered phase, the same fault also puts the wrong byte on portAIn in that cycle. The bench compares every output to its own model on every clock, so any such divergence is reported in the first cycle it appears.

// File: rtl/busSteerPkg.sv
package busSteerPkg;

  // Stored extension configuration; field order fixes the bit positions
  // (routeRtc is bit 5, modeAux bit 0) used when loading from the data bus.
  typedef struct packed {
    logic routeRtc;
    logic tmrEn;
    logic blank;
    logic extColor;
    logic hiRes;
    logic modeAux;
  } extCfg_t;

  localparam int CFG_W = $bits(extCfg_t);

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic rtcAs;
    logic rtcDs;
    logic rtcRead;
    logic tmrWr;
  } steerStrobe_t;

  // Clock cycle codes carried on the three control bits.
  localparam logic [2:0] RTC_CODE_ADDR = 3'd2;
  localparam logic [2:0] RTC_CODE_WR   = 3'd4;
  localparam logic [2:0] RTC_CODE_RD   = 3'd5;

endpackage

// File: rtl/steerCtrl.sv
module steerCtrl
  import busSteerPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ZERO_BIT_A  = 10,
  parameter int ZERO_BIT_B  = 8,
  parameter int ONE_BIT     = 7,
  parameter bit REG_STROBES = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWr,
  input  logic [2:0]        ctlBits,
  output extCfg_t           cfgQ,
  output steerStrobe_t      strobe
);

  logic extHit;
  logic asNext;
  logic dsNext;
  logic rdNext;
  logic unusedIo;

  // Partial address decode for the extension register (R2)
  assign extHit = ioWr && !ioAddr[ZERO_BIT_A] && !ioAddr[ZERO_BIT_B] && ioAddr[ONE_BIT];

  // Upper data bits and the undecoded address bits carry no meaning here
  assign unusedIo = ^{ioAddr, ioData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (extHit) begin
      cfgQ <= extCfg_t'(ioData[CFG_W-1:0]);
    end
  end

  // Decode of the software-driven clock cycle code (R5..R8)
  always_comb begin
    asNext = 1'b0;
    dsNext = 1'b0;
    rdNext = 1'b0;
    if (cfgQ.routeRtc) begin
      unique case (ctlBits)
        RTC_CODE_ADDR: asNext = 1'b1;
        RTC_CODE_WR:   dsNext = 1'b1;
        RTC_CODE_RD: begin
          dsNext = 1'b1;
          rdNext = 1'b1;
        end
        default: ;
      endcase
    end
  end

  generate
    if (REG_STROBES) begin : gRegStrobe
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          strobe.rtcAs   <= 1'b0;
          strobe.rtcDs   <= 1'b0;
          strobe.rtcRead <= 1'b0;
        end else begin
          strobe.rtcAs   <= asNext;
          strobe.rtcDs   <= dsNext;
          strobe.rtcRead <= rdNext;
        end
      end
    end else begin : gCombStrobe
      assign strobe.rtcAs   = asNext;
      assign strobe.rtcDs   = dsNext;
      assign strobe.rtcRead = rdNext;
    end
  endgenerate

  // Timer shadows every I/O write while enabled (R9)
  assign strobe.tmrWr = ioWr && cfgQ.tmrEn;

endmodule

// File: rtl/steerDatapath.sv
module steerDatapath
  import busSteerPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SCTL_W = 2,
  parameter int TSEL_W = 2
) (
  input  extCfg_t           cfgQ,
  input  steerStrobe_t      strobe,
  input  logic [TSEL_W-1:0] tmrSel,
  input  logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAIn,
  input  logic [SCTL_W-1:0] soundCtlIn,
  output logic [SCTL_W-1:0] soundCtlOut,
  output logic [DATA_W-1:0] soundDataOut,
  input  logic [DATA_W-1:0] soundDataIn,
  output logic              rtcAs,
  output logic              rtcDs,
  output logic              rtcRead,
  output logic [DATA_W-1:0] rtcBusOut,
  output logic              rtcBusDrive,
  input  logic [DATA_W-1:0] rtcDataIn,
  output logic              tmrWr,
  output logic [TSEL_W-1:0] tmrAddr,
  output logic [DATA_W-1:0] tmrData,
  output logic              videoBlank,
  output logic              extColor,
  output logic              hiResX,
  output logic              modeAux
);

  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  logic unusedCfg;
  assign unusedCfg = cfgQ.tmrEn;

  // Sound control lines are parked while the clock owns the port (R3, R4)
  for (genvar i = 0; i < SCTL_W; i++) begin : gSndGate
    assign soundCtlOut[i] = soundCtlIn[i] & ~cfgQ.routeRtc;
  end

  // Return path into the parallel port (R3, R7, R8)
  always_comb begin
    if (strobe.rtcRead) begin
      portAIn = rtcDataIn;
    end else if (!cfgQ.routeRtc) begin
      portAIn = soundDataIn;
    end else begin
      portAIn = IDLE_BYTE;
    end
  end

  assign soundDataOut = portAOut;
  assign rtcBusOut    = portAOut;
  assign rtcBusDrive  = cfgQ.routeRtc & ~strobe.rtcRead;
  assign rtcAs        = strobe.rtcAs;
  assign rtcDs        = strobe.rtcDs;
  assign rtcRead      = strobe.rtcRead;

  assign tmrWr   = strobe.tmrWr;
  assign tmrAddr = tmrSel;
  assign tmrData = portAOut;

  assign videoBlank = cfgQ.blank;
  assign extColor   = cfgQ.extColor;
  assign hiResX     = cfgQ.hiRes;
  assign modeAux    = cfgQ.modeAux;

endmodule

// File: rtl/busSteer.sv
module busSteer
  import busSteerPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAIn,
  input  logic [2:0]        ctlBits,
  input  logic [1:0]        soundCtlIn,
  output logic [1:0]        soundCtlOut,
  output logic [DATA_W-1:0] soundDataOut,
  input  logic [DATA_W-1:0] soundDataIn,
  output logic              rtcAs,
  output logic              rtcDs,
  output logic              rtcRead,
  output logic [DATA_W-1:0] rtcBusOut,
  output logic              rtcBusDrive,
  input  logic [DATA_W-1:0] rtcDataIn,
  output logic              tmrWr,
  output logic [1:0]        tmrAddr,
  output logic [DATA_W-1:0] tmrData,
  output logic              videoBlank,
  output logic              extColor,
  output logic              hiResX,
  output logic              modeAux
);

  extCfg_t      cfgQ;
  steerStrobe_t strobe;

  steerCtrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ioAddr (ioAddr),
    .ioData (ioData),
    .ioWr   (ioWr),
    .ctlBits(ctlBits),
    .cfgQ   (cfgQ),
    .strobe (strobe)
  );

  steerDatapath #(
    .DATA_W(DATA_W),
    .SCTL_W(2),
    .TSEL_W(2)
  ) uPath (
    .cfgQ        (cfgQ),
    .strobe      (strobe),
    .tmrSel      (ioAddr[1:0]),
    .portAOut    (portAOut),
    .portAIn     (portAIn),
    .soundCtlIn  (soundCtlIn),
    .soundCtlOut (soundCtlOut),
    .soundDataOut(soundDataOut),
    .soundDataIn (soundDataIn),
    .rtcAs       (rtcAs),
    .rtcDs       (rtcDs),
    .rtcRead     (rtcRead),
    .rtcBusOut   (rtcBusOut),
    .rtcBusDrive (rtcBusDrive),
    .rtcDataIn   (rtcDataIn),
    .tmrWr       (tmrWr),
    .tmrAddr     (tmrAddr),
    .tmrData     (tmrData),
    .videoBlank  (videoBlank),
    .extColor    (extColor),
    .hiResX      (hiResX),
    .modeAux     (modeAux)
  );

endmodule

// File: rtl/busSteerChk.sv
module busSteerChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              routeRtc,
  input logic              ioWr,
  input logic [2:0]        ctlBits,
  input logic [1:0]        soundCtlOut,
  input logic              rtcAs,
  input logic              rtcDs,
  input logic              rtcRead,
  input logic              rtcBusDrive,
  input logic [DATA_W-1:0] rtcDataIn,
  input logic [DATA_W-1:0] portAIn,
  input logic              tmrWr,
  input logic              videoBlank,
  input logic              hiResX
);

  assert_as_ds_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    rtcAs |-> !rtcDs);

  assert_addr_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    (routeRtc && ctlBits == 3'd2) |=> rtcAs);

  assert_sound_parked_R4: assert property (@(posedge clk) disable iff (!rstN)
    routeRtc |-> soundCtlOut == 2'b00);

  assert_rtc_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !routeRtc |=> (!rtcAs && !rtcDs && !rtcRead));

  assert_drive_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    rtcBusDrive |-> !rtcRead);

  assert_read_return_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rtcDs && rtcRead) |-> portAIn == rtcDataIn);

  assert_tmr_needs_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    tmrWr |-> ioWr);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ioWr |=> ($stable(videoBlank) && $stable(hiResX)));

endmodule

bind busSteer busSteerChk #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .routeRtc   (cfgQ.routeRtc),
  .ioWr       (ioWr),
  .ctlBits    (ctlBits),
  .soundCtlOut(soundCtlOut),
  .rtcAs      (rtcAs),
  .rtcDs      (rtcDs),
  .rtcRead    (rtcRead),
  .rtcBusDrive(rtcBusDrive),
  .rtcDataIn  (rtcDataIn),
  .portAIn    (portAIn),
  .tmrWr      (tmrWr),
  .videoBlank (videoBlank),
  .hiResX     (hiResX)
);

// File: tb/tb_busSteer.sv
`timescale 1ns/1ps
module tb_busSteer;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ioAddr;
  logic [7:0]  ioData;
  logic        ioWr;
  logic [7:0]  portAOut;
  logic [7:0]  portAIn;
  logic [2:0]  ctlBits;
  logic [1:0]  soundCtlIn;
  logic [1:0]  soundCtlOut;
  logic [7:0]  soundDataOut;
  logic [7:0]  soundDataIn;
  logic        rtcAs, rtcDs, rtcRead;
  logic [7:0]  rtcBusOut;
  logic        rtcBusDrive;
  logic [7:0]  rtcDataIn;
  logic        tmrWr;
  logic [1:0]  tmrAddr;
  logic [7:0]  tmrData;
  logic        videoBlank, extColor, hiResX, modeAux;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  busSteer dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioData(ioData), .ioWr(ioWr),
    .portAOut(portAOut), .portAIn(portAIn), .ctlBits(ctlBits),
    .soundCtlIn(soundCtlIn), .soundCtlOut(soundCtlOut),
    .soundDataOut(soundDataOut), .soundDataIn(soundDataIn),
    .rtcAs(rtcAs), .rtcDs(rtcDs), .rtcRead(rtcRead), .rtcBusOut(rtcBusOut),
    .rtcBusDrive(rtcBusDrive), .rtcDataIn(rtcDataIn), .tmrWr(tmrWr),
    .tmrAddr(tmrAddr), .tmrData(tmrData), .videoBlank(videoBlank),
    .extColor(extColor), .hiResX(hiResX), .modeAux(modeAux)
  );

  // Behavioural reference state
  bit [5:0] mExt;
  bit       mAs, mDs, mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mExt = 6'd0; mAs = 0; mDs = 0; mRd = 0;
    end else begin
      bit rtcOn;
      rtcOn = mExt[5];
      mAs = rtcOn && (ctlBits == 3'd2);
      mDs = rtcOn && (ctlBits == 3'd4 || ctlBits == 3'd5);
      mRd = rtcOn && (ctlBits == 3'd5);
      if (ioWr && !ioAddr[10] && !ioAddr[8] && ioAddr[7]) mExt = ioData[5:0];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      logic [7:0] expIn;
      expIn = mRd ? rtcDataIn : (mExt[5] ? 8'hFF : soundDataIn);
      chk("R2", "videoBlank", videoBlank, mExt[3]);
      chk("R2", "extColor", extColor, mExt[2]);
      chk("R2", "hiResX", hiResX, mExt[1]);
      chk("R2", "modeAux", modeAux, mExt[0]);
      chk("R4", "soundCtlOut", soundCtlOut, mExt[5] ? 2'b00 : soundCtlIn);
      chk("R5", "rtcAs", rtcAs, mAs);
      chk("R6", "rtcDs", rtcDs, mDs);
      chk("R7", "rtcRead", rtcRead, mRd);
      chk("R7", "portAIn", portAIn, expIn);
      chk("R6", "rtcBusDrive", rtcBusDrive, mExt[5] && !mRd);
      chk("R6", "rtcBusOut", rtcBusOut, portAOut);
      chk("R3", "soundDataOut", soundDataOut, portAOut);
      chk("R9", "tmrWr", tmrWr, ioWr && mExt[4]);
      chk("R9", "tmrAddr", tmrAddr, ioAddr[1:0]);
      chk("R9", "tmrData", tmrData, portAOut);
    end
  end

  task automatic advance();
    @(negedge clk); #1;
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    ioAddr = a; ioData = d; ioWr = 1'b1;
    advance();
    ioWr = 1'b0; ioAddr = 16'h0000;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; ioAddr = 0; ioData = 0; ioWr = 0; portAOut = 8'h5A;
    ctlBits = 3'd2; soundCtlIn = 2'b11; soundDataIn = 8'h3C; rtcDataIn = 8'h99;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "videoBlank", videoBlank, 0);
    chk("R1", "hiResX", hiResX, 0);
    chk("R1", "rtcAs", rtcAs, 0);
    chk("R1", "rtcDs", rtcDs, 0);
    chk("R1", "soundCtlOut", soundCtlOut, 2'b11);
    chk("R1", "portAIn", portAIn, 8'h3C);
    #1 rstN = 1'b1;
    advance();

    // R2 non-matching addresses and bits 7:6 are ignored
    ioWrite(16'hFE80, 8'h3F);
    ioWrite(16'hFB80, 8'h3F);
    ioWrite(16'hFA00, 8'h3F);
    advance();
    chk("R2", "no load on miss", {videoBlank, extColor, hiResX, modeAux}, 4'b0000);
    ioWrite(16'hFA80, 8'hCE);
    @(negedge clk);
    chk("R2", "fields after load", {videoBlank, extColor, hiResX, modeAux}, 4'b1110);
    chk("R2", "route stays sound", soundCtlOut, soundCtlIn);
    #1;

    // R3 sound routing with varied patterns
    for (int i = 0; i < 8; i++) begin
      soundCtlIn = i[1:0]; soundDataIn = 8'h11 * i[7:0]; portAOut = 8'hF0 ^ i[7:0];
      ctlBits = i[2:0];
      advance();
    end

    // Route to the clock, walk all control codes
    ioWrite(16'hFA80, 8'h21);
    soundCtlIn = 2'b11;
    for (int c = 0; c < 8; c++) begin
      ctlBits = c[2:0]; rtcDataIn = 8'hA0 + c[7:0]; portAOut = 8'h0F + c[7:0];
      advance();
      @(negedge clk);
      if (c == 2) chk("R5", "address strobe", {rtcAs, rtcDs}, 2'b10);
      if (c == 4) chk("R6", "write strobe", {rtcDs, rtcRead, rtcBusDrive}, 3'b101);
      if (c == 5) chk("R7", "read data", portAIn, 8'hA5);
      if (c == 7) chk("R8", "idle byte", portAIn, 8'hFF);
      if (c == 0) chk("R8", "idle strobes", {rtcAs, rtcDs, rtcRead}, 3'b000);
      chk("R4", "sound parked", soundCtlOut, 2'b00);
      #1;
    end

    // Switch back to sound while a read code is held
    ctlBits = 3'd5; advance(); advance();
    ioWrite(16'hFA80, 8'h00);
    @(negedge clk);
    chk("R3", "strobes cleared", {rtcAs, rtcDs, rtcRead}, 3'b000);
    chk("R3", "sound returns", portAIn, soundDataIn);
    #1;

    // R9 timer enabled: writes to many addresses
    ioWrite(16'hFA80, 8'h30);
    for (int k = 0; k < 6; k++) begin
      portAOut = 8'h40 + k[7:0];
      ioAddr = 16'hF400 + k[15:0]; ioData = 8'h77; ioWr = 1'b1;
      @(negedge clk);
      chk("R9", "timer strobe", {tmrWr, tmrAddr}, {1'b1, k[1:0]});
      chk("R9", "timer data", tmrData, 8'h40 + k[7:0]);
      #1 ioWr = 1'b0;
      advance();
    end
    ioWrite(16'hFA80, 8'h00);
    ioAddr = 16'h1233; ioWr = 1'b1;
    @(negedge clk);
    chk("R9", "timer off", tmrWr, 0);
    #1 ioWr = 1'b0;
    advance(); advance();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule